// File: doc/BRIEF.md
# System Tick Compare Timer

The block keeps a free-running system tick counter and two compare registers. One compare serves the supervisor, the other the hypervisor. The counter advances by one on each tick-enable pulse and wraps at its width. Each compare register is one bit wider than the counter. Its top bit turns the compare off, and the bits below it hold the target count. When the counter steps onto an armed and enabled target, that compare produces a single match.

A supervisor match produces a one-cycle pulse, which requests that soft interrupt bit 16 be set in an interrupt register outside this block. A hypervisor match sets a pending flag, and that flag drives the hypervisor interrupt line. The hypervisor compare is silenced while the thread is halted.

Software reaches the block through a simple write port and a combinational read port. One address holds the counter, one holds each compare register, and one holds the pending flag. A compare is armed only when its target is ahead of the counter at the time it is written. An armed compare fires once. After that it stays quiet until the counter wraps or the register is written again.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the counter reads 0, both compare registers read with only the top (disable) bit set, the pending flag reads 0, and both interrupt outputs are low.
- R2: Each cycle with `tick_en` high and no counter write adds one to the counter, modulo 2^CNT_W. The counter wraps from all ones to zero.
- R3: A write to address 0 loads `wr_data[CNT_W-1:0]` into the counter. The write wins over a tick in the same cycle, and no compare fires on the edge of that write.
- R4: For an armed and enabled supervisor compare, `soft16_set` is high for exactly one cycle. That cycle is the first one in which the counter reads the target.
- R5: Bit CNT_W of a compare register disables that compare, and only bits CNT_W-1:0 are compared. Writing a value with the disable bit set cancels a pending match.
- R6: A compare whose target is not greater than the counter value after the write edge is not armed by that write. It stays silent until the counter wraps.
- R7: When the counter wraps, an enabled compare is re-armed. It then fires again when the counter reaches its target.
- R8: An enabled hypervisor match sets the pending flag one cycle after the match. `hyp_irq` equals the flag. The flag stays set until software writes 0 to address 3, and a write of 1 sets it.
- R9: While `halted` is high on the edge on which the counter reaches the hypervisor target, the match is dropped and the pending flag is not set.
- R10: `rd_data` shows the selected state with zeros above the field. Address 0 shows the counter, address 1 the supervisor compare, address 2 the hypervisor compare, and address 3 the pending flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Advances the counter by one |
| halted | input | 1 | Thread halted; suppresses the hypervisor compare |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 counter, 1 supervisor, 2 hypervisor, 3 pending) |
| wr_data | input | CNT_W+1 (64) | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | CNT_W+1 (64) | Read data, combinational |
| soft16_set | output | 1 | One-cycle request to set soft interrupt bit 16 |
| hyp_irq | output | 1 | Hypervisor interrupt, follows the pending flag |

## Verification
The compare logic is tried with targets placed just ahead of the counter, equal to it, and behind it. This separates a correctly armed compare from one that fires on a target that was not ahead or that never fires at all. Rewriting an armed compare with the disable bit set shows whether a pending match is actually cancelled. Running a target across a counter wrap checks both parts of the wrap rule: a target written behind the counter fires only after the wrap, and an enabled compare fires once per lap. Hypervisor targets reached with `halted` high and low tell suppression apart from routing, and random writes that land in the same cycle as ticks test the priority of a counter write over a tick.

// File: rtl/tct_pkg.sv
package tct_pkg;

    typedef enum logic [1:0] {
        ADR_COUNT = 2'd0,
        ADR_SUP   = 2'd1,
        ADR_HYP   = 2'd2,
        ADR_PEND  = 2'd3
    } tct_addr_e;

    localparam int NUM_CMP = 2;
    localparam int CMP_SUP = 0;
    localparam int CMP_HYP = 1;

endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             adv,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        adv     = tick_en & ~load;
        wrap    = adv & (&state_q.cnt);
        if (load) begin
            state_d.cnt = load_val;
        end else if (tick_en) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_q    = state_q.cnt;
    assign cnt_next = state_d.cnt;

    // R2: one tick adds exactly one
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R2: wrap lands on zero
    p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    // R3: a load wins over a tick
    p_cnt_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/tct_compare.sv
module tct_compare #(
    parameter int CNT_W = 63,
    localparam int REG_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_val,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             cnt_load,
    input  logic             adv,
    input  logic             wrap,
    input  logic             suppress,
    output logic [REG_W-1:0] reg_q,
    output logic             match_q
);

    typedef struct packed {
        logic [REG_W-1:0] cmp;
        logic             armed;
        logic             match;
    } cmp_state_t;

    localparam logic [REG_W-1:0] CMP_RST = {1'b1, {CNT_W{1'b0}}};

    cmp_state_t       state_d, state_q;
    logic [CNT_W-1:0] tgt;
    logic             dis;
    logic             live;
    logic             hit;

    always_comb begin
        state_d       = state_q;
        state_d.match = 1'b0;
        tgt           = state_q.cmp[CNT_W-1:0];
        dis           = state_q.cmp[CNT_W];
        live          = state_q.armed | wrap;
        hit           = 1'b0;
        if (wr_en) begin
            state_d.cmp   = wr_val;
            state_d.armed = ~wr_val[CNT_W] & (wr_val[CNT_W-1:0] > cnt_next);
        end else if (cnt_load) begin
            state_d.armed = ~dis & (tgt > cnt_next);
        end else if (adv) begin
            hit           = live & ~dis & (cnt_next == tgt);
            state_d.match = hit & ~suppress;
            state_d.armed = live & ~dis & ~hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cmp: CMP_RST, armed: 1'b0, match: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_q   = state_q.cmp;
    assign match_q = state_q.match;

    // R4: a match shows in the cycle the counter reads the target
    p_hit_on_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> (cnt_q == reg_q[CNT_W-1:0]));

    // R4: pulse lasts a single cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |=> !match_q);

    // R5: a disabled compare never fires
    p_disabled_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> !reg_q[CNT_W]);

    // R3: no match on the edge of a counter load
    p_no_hit_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> !match_q);

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tct_pkg::*;
#(
    parameter int CNT_W = 63,
    localparam int REG_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halted,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    output logic             soft16_set,
    output logic             hyp_irq
);

    typedef struct packed {
        logic pend;
    } pend_state_t;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             cnt_load;
    logic             adv;
    logic             wrap;
    logic [REG_W-1:0] cmp_val [NUM_CMP];
    logic             cmp_hit [NUM_CMP];
    pend_state_t      pend_d, pend_q;

    assign cnt_load = wr_en & (wr_addr == ADR_COUNT);

    tct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (cnt_load),
        .load_val (wr_data[CNT_W-1:0]),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .adv      (adv),
        .wrap     (wrap)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        logic sel;
        logic quiet;
        assign sel   = wr_en & (wr_addr == 2'(i + 1));
        assign quiet = (i == CMP_HYP) ? halted : 1'b0;
        tct_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel),
            .wr_val   (wr_data),
            .cnt_q    (cnt_q),
            .cnt_next (cnt_next),
            .cnt_load (cnt_load),
            .adv      (adv),
            .wrap     (wrap),
            .suppress (quiet),
            .reg_q    (cmp_val[i]),
            .match_q  (cmp_hit[i])
        );
    end

    always_comb begin
        pend_d = pend_q;
        if (cmp_hit[CMP_HYP]) begin
            pend_d.pend = 1'b1;
        end else if (wr_en && wr_addr == ADR_PEND) begin
            pend_d.pend = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (tct_addr_e'(rd_addr))
            ADR_COUNT: rd_data[CNT_W-1:0] = cnt_q;
            ADR_SUP:   rd_data = cmp_val[CMP_SUP];
            ADR_HYP:   rd_data = cmp_val[CMP_HYP];
            default:   rd_data[0] = pend_q.pend;
        endcase
    end

    assign soft16_set = cmp_hit[CMP_SUP];
    assign hyp_irq    = pend_q.pend;

    // R9: no hypervisor match when halted on the matching edge
    p_halt_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit[CMP_HYP] |-> !$past(halted));

    // R8: the interrupt only rises from a match or a software set
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hyp_irq) |-> ($past(cmp_hit[CMP_HYP])
                            || $past(wr_en && wr_addr == ADR_PEND && wr_data[0])));

    // R8: the interrupt holds until software writes the flag
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hyp_irq && !(wr_en && wr_addr == ADR_PEND)) |=> hyp_irq);

endmodule

// File: tb/tick_cmp_timer_test.sv
`timescale 1ns/1ps
module tick_cmp_timer_test;

    localparam int W  = 8;
    localparam int RW = W + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          halted = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [RW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [RW-1:0] rd_data;
    logic          soft16_set;
    logic          hyp_irq;

    int n_chk = 0;
    int n_fail = 0;
    int sup_pulses = 0;
    int hyp_rises = 0;

    logic [W-1:0]  m_cnt;
    logic [RW-1:0] m_cmp   [2];
    logic          m_arm   [2];
    logic          m_match [2];
    logic          m_pend;

    tick_cmp_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halted(halted),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .soft16_set(soft16_set), .hyp_irq(hyp_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [RW-1:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {1'b0, m_cnt};
            2'd1:    return m_cmp[0];
            2'd2:    return m_cmp[1];
            default: return {{(RW-1){1'b0}}, m_pend};
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = '0;
        m_pend = 1'b0;
        for (int i = 0; i < 2; i++) begin
            m_cmp[i] = {1'b1, {W{1'b0}}};
            m_arm[i] = 1'b0;
            m_match[i] = 1'b0;
        end
    endtask

    task automatic model_step(input logic t, input logic h, input logic we,
                              input logic [1:0] wa, input logic [RW-1:0] wd);
        logic [W-1:0] nc;
        logic         cw;
        logic         wp;
        logic         live;
        logic         hit;
        logic         nm [2];
        cw = we && wa == 2'd0;
        wp = !cw && t && (m_cnt == {W{1'b1}});
        nc = cw ? wd[W-1:0] : (t ? m_cnt + 1'b1 : m_cnt);
        for (int i = 0; i < 2; i++) begin
            nm[i] = 1'b0;
            if (we && wa == 2'(i + 1)) begin
                m_cmp[i] = wd;
                m_arm[i] = !wd[W] && (wd[W-1:0] > nc);
            end else if (cw) begin
                m_arm[i] = !m_cmp[i][W] && (m_cmp[i][W-1:0] > nc);
            end else if (t) begin
                live = m_arm[i] || wp;
                hit = live && !m_cmp[i][W] && (nc == m_cmp[i][W-1:0]);
                nm[i] = hit && !(i == 1 && h);
                m_arm[i] = live && !m_cmp[i][W] && !hit;
            end
        end
        if (m_match[1]) m_pend = 1'b1;
        else if (we && wa == 2'd3) m_pend = wd[0];
        m_cnt = nc;
        m_match[0] = nm[0];
        m_match[1] = nm[1];
    endtask

    task automatic step(input logic t, input logic h, input logic we,
                        input logic [1:0] wa, input logic [RW-1:0] wd, input logic [1:0] ra);
        logic irq_before;
        irq_before = hyp_irq;
        tick_en = t; halted = h; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        model_step(t, h, we, wa, wd);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        tick_en = 1'b0;
        check(ra == 2'd0 ? "R2 R10 counter read" : "R10 register read", rd_data, exp_rd(ra));
        check("R4 soft16_set pulse", {{(RW-1){1'b0}}, soft16_set}, {{(RW-1){1'b0}}, m_match[0]});
        check("R8 hyp_irq level", {{(RW-1){1'b0}}, hyp_irq}, {{(RW-1){1'b0}}, m_pend});
        if (soft16_set) sup_pulses++;
        if (hyp_irq && !irq_before) hyp_rises++;
    endtask

    task automatic ticks(input int n, input logic h);
        for (int k = 0; k < n; k++) step(1'b1, h, 1'b0, 2'd0, '0, 2'(k % 4));
    endtask

    task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
        step(1'b0, 1'b0, 1'b1, a, d, a);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1;
            check("R1 reset read", rd_data, exp_rd(2'(a)));
        end
        check("R1 reset soft16_set", {{(RW-1){1'b0}}, soft16_set}, '0);
        check("R1 reset hyp_irq", {{(RW-1){1'b0}}, hyp_irq}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: target three ahead
        wr(2'd0, 9'd10);
        wr(2'd1, 9'd13);
        sup_pulses = 0;
        ticks(6, 1'b0);
        check("R4 one pulse for target 13", 9'(sup_pulses), 9'd1);

        // R3: load beats a tick
        step(1'b1, 1'b0, 1'b1, 2'd0, 9'd20, 2'd0);
        check("R3 counter load with tick", rd_data, 9'd20);

        // R5: disable cancels an armed compare
        wr(2'd0, 9'd30);
        wr(2'd1, 9'd33);
        wr(2'd1, 9'h100 | 9'd33);
        sup_pulses = 0;
        ticks(6, 1'b0);
        check("R5 disabled compare silent", 9'(sup_pulses), 9'd0);

        // R6: target equal to, then behind, the counter
        wr(2'd0, 9'd40);
        wr(2'd1, 9'd40);
        sup_pulses = 0;
        ticks(5, 1'b0);
        wr(2'd1, 9'd39);
        ticks(5, 1'b0);
        check("R6 target not ahead stays silent", 9'(sup_pulses), 9'd0);

        // R7: behind-target fires after wrap; ahead-target fires once per lap
        wr(2'd0, 9'd250);
        wr(2'd1, 9'd5);
        sup_pulses = 0;
        ticks(12, 1'b0);
        check("R7 fires after wrap", 9'(sup_pulses), 9'd1);
        wr(2'd0, 9'd250);
        wr(2'd1, 9'd252);
        sup_pulses = 0;
        ticks(262, 1'b0);
        check("R7 fires once per lap", 9'(sup_pulses), 9'd2);

        // R9: halted hides the hypervisor match
        wr(2'd3, 9'd0);
        wr(2'd0, 9'd60);
        wr(2'd2, 9'd62);
        hyp_rises = 0;
        ticks(5, 1'b1);
        check("R9 halted hyp silent", {{(RW-1){1'b0}}, hyp_irq}, '0);
        // R8: match sets the flag, software clears it
        wr(2'd2, 9'd70);
        ticks(12, 1'b0);
        check("R8 hyp match raises irq", {{(RW-1){1'b0}}, hyp_irq}, 9'd1);
        ticks(3, 1'b0);
        check("R8 irq held", {{(RW-1){1'b0}}, hyp_irq}, 9'd1);
        wr(2'd3, 9'd0);
        check("R8 irq cleared by write", {{(RW-1){1'b0}}, hyp_irq}, '0);
        check("R8 one rise", 9'(hyp_rises), 9'd1);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic          t, h, we;
            logic [1:0]    wa;
            logic [RW-1:0] wd;
            t  = ($urandom % 4) != 0;
            h  = ($urandom % 3) == 0;
            we = ($urandom % 6) == 0;
            wa = 2'($urandom % 4);
            wd = 9'($urandom);
            if (wa != 2'd0) wd = {($urandom % 4) == 0, W'(m_cnt + 8'($urandom % 8))};
            step(t, h, we, wa, wd, 2'($urandom % 4));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule